// File: doc/BRIEF.md
# Lane-Splittable Unsigned Word Comparator

This block compares two 16-bit words under one of six relations: equal, not equal, less than, less or equal, greater than and greater or equal. At run time the word can be cut into independent lanes on nibble boundaries. It can be one 16-bit lane, two byte lanes, four nibble lanes, or any other mix of contiguous nibble groups. Each lane is compared as an unsigned integer. The answer for a lane is written into every result bit that covers one of that lane's nibbles. A consumer that thinks in lanes can therefore read any bit of its lane, and a consumer that thinks in nibbles can use the vector directly as a per-nibble predicate mask.

The comparator is purely combinational and has no clock, so the result follows the inputs in the same cycle. For each lane it builds an equality chain and a greater-than chain, running from the lane's lowest nibble up to its highest. The selected relation is taken from these two chains at the lane's top nibble and then copied down across the lane.

Top module: `simd_lane_cmp`

## Requirements
- R1: With no lane boundary requested (split bits 2..0 all zero), all four result bits equal the selected relation applied to the full 16-bit operands.
- R2: Split bit i (i = 0, 1, 2) places a lane boundary between nibble i and nibble i+1 (nibble 0 is bits 3..0). Split bit 3 has no effect. The pattern 0b0010 gives two byte lanes, and 0b1111 gives four nibble lanes.
- R3: Every result bit whose nibble lies in a given lane carries that lane's single answer. For example, a true upper-byte compare sets bits 3 and 2, giving 0b1100.
- R4: Op encoding: 0 equal, 1 not equal, 2 less than, 3 less or equal, 4 greater than, 5 greater or equal. Codes 6 and 7 drive all result bits to 0.
- R5: Lane values are unsigned. 0x8000 compares greater than 0x0000 in a full-width lane.
- R6: A lane is equal only when every one of its nibbles matches. Operands that differ only in nibble 0 are unequal in a 16-bit lane.
- R7: Inside a lane, the order is decided by the most significant nibble that differs. Lower nibbles do not change it.
- R8: The result depends only on the present inputs. It changes without any clock edge.
- R9: A lane's result bits do not depend on operand nibbles that lie outside the lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | Left operand |
| b_i | input | 16 | Right operand |
| op_i | input | 3 | Relation select (encoding in R4) |
| split_i | input | 4 | Lane boundary control, one bit per nibble gap (R2) |
| res_o | output | 4 | Per-nibble result, replicated across each lane |

## Verification
Embedded immediate assertions are evaluated on every input change. They check four things: adjacent result bits agree wherever no boundary separates them; the full-width case matches a direct 16-bit equality and greater-than; nibble-split equality matches each nibble; and the unused op codes return zero. In the chain, equal and greater can never both hold. Three properties are shown only by the bench scenarios: split bit 3 being ignored, ordering at the most significant differing nibble across mixed lane patterns, and the independence of one lane from changes in another.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;

   typedef enum logic [2:0] {
      CMP_EQ = 3'd0,
      CMP_NE = 3'd1,
      CMP_LT = 3'd2,
      CMP_LE = 3'd3,
      CMP_GT = 3'd4,
      CMP_GE = 3'd5
   } cmp_op_e;

   // Map (equal, greater) of a lane onto the requested relation.
   function automatic logic rel_pick(input logic [2:0] op,
                                     input logic       is_eq,
                                     input logic       is_gt);
      logic r;
      case (op)
         CMP_EQ:  r = is_eq;
         CMP_NE:  r = !is_eq;
         CMP_LT:  r = !is_eq && !is_gt;
         CMP_LE:  r = !is_gt;
         CMP_GT:  r = is_gt;
         CMP_GE:  r = is_gt || is_eq;
         default: r = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/simd_cmp_unit.sv
// Per-nibble primitive compare: equal and unsigned greater-than.
module simd_cmp_unit #(
   parameter int UNIT_W = 4
) (
   input  logic [UNIT_W-1:0] a_i,
   input  logic [UNIT_W-1:0] b_i,
   output logic              eq_o,
   output logic              gt_o
);
   if (UNIT_W < 1) begin : g_bad_w
      $error("simd_cmp_unit: UNIT_W must be at least 1");
   end

   always_comb begin
      eq_o = (a_i == b_i);
      gt_o = (a_i > b_i);
   end
endmodule

// File: rtl/simd_cmp_chain.sv
// Lane-local accumulation from each lane's low unit upward.
module simd_cmp_chain #(
   parameter int UNITS = 4
) (
   input  logic [UNITS-1:0] eq_u_i,
   input  logic [UNITS-1:0] gt_u_i,
   input  logic [UNITS-1:0] bound_i,   // bound_i[k]: lane ends at unit k
   output logic [UNITS-1:0] ceq_o,
   output logic [UNITS-1:0] cgt_o
);
   if (UNITS < 2) begin : g_bad_units
      $error("simd_cmp_chain: UNITS must be at least 2");
   end

   for (genvar k = 0; k < UNITS; k++) begin : g_link
      if (k == 0) begin : g_first
         assign ceq_o[k] = eq_u_i[k];
         assign cgt_o[k] = gt_u_i[k];
      end else begin : g_next
         logic fresh;
         assign fresh    = bound_i[k-1];
         assign ceq_o[k] = eq_u_i[k] && (fresh || ceq_o[k-1]);
         assign cgt_o[k] = gt_u_i[k] || (eq_u_i[k] && !fresh && cgt_o[k-1]);
      end
   end

   always_comb begin
      for (int k = 0; k < UNITS; k++) begin
         assert_eq_gt_excl_R7: assert (!(ceq_o[k] && cgt_o[k]))
            else $error("chain unit %0d both equal and greater", k);
      end
   end
endmodule

// File: rtl/simd_cmp_spread.sv
// Copies each lane's top-unit answer down across the lane.
module simd_cmp_spread #(
   parameter int UNITS = 4
) (
   input  logic [UNITS-1:0] top_val_i,
   input  logic [UNITS-1:0] bound_i,
   output logic [UNITS-1:0] res_o
);
   for (genvar k = UNITS - 1; k >= 0; k--) begin : g_fill
      if (k == UNITS - 1) begin : g_top
         assign res_o[k] = top_val_i[k];
      end else begin : g_mid
         assign res_o[k] = bound_i[k] ? top_val_i[k] : res_o[k+1];
      end
   end
endmodule

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp
   import simd_cmp_pkg::*;
#(
   parameter int UNIT_W = 4,
   parameter int UNITS  = 4
) (
   input  logic [UNIT_W*UNITS-1:0] a_i,
   input  logic [UNIT_W*UNITS-1:0] b_i,
   input  logic [2:0]              op_i,
   input  logic [UNITS-1:0]        split_i,
   output logic [UNITS-1:0]        res_o
);
   localparam int WORD_W = UNIT_W * UNITS;

   if (UNITS < 2) begin : g_bad_units
      $error("simd_lane_cmp: UNITS must be at least 2");
   end

   logic [UNITS-1:0] eq_u, gt_u, ceq, cgt, bound, top_val;

   // The highest unit always closes a lane; its split bit is unused.
   assign bound = {1'b1, split_i[UNITS-2:0]};

   for (genvar k = 0; k < UNITS; k++) begin : g_unit
      simd_cmp_unit #(.UNIT_W(UNIT_W)) i_unit (
         .a_i (a_i[k*UNIT_W +: UNIT_W]),
         .b_i (b_i[k*UNIT_W +: UNIT_W]),
         .eq_o(eq_u[k]),
         .gt_o(gt_u[k])
      );
      assign top_val[k] = rel_pick(op_i, ceq[k], cgt[k]);
   end

   simd_cmp_chain #(.UNITS(UNITS)) i_chain (
      .eq_u_i (eq_u),
      .gt_u_i (gt_u),
      .bound_i(bound),
      .ceq_o  (ceq),
      .cgt_o  (cgt)
   );

   simd_cmp_spread #(.UNITS(UNITS)) i_spread (
      .top_val_i(top_val),
      .bound_i  (bound),
      .res_o    (res_o)
   );

   always_comb begin
      for (int k = 0; k < UNITS - 1; k++) begin
         if (!split_i[k]) begin
            assert_lane_uniform_R3: assert (res_o[k] == res_o[k+1])
               else $error("bits %0d and %0d differ inside a lane", k, k + 1);
         end
      end
      if (split_i[UNITS-2:0] == '0 && op_i == CMP_EQ) begin
         assert_full_eq_R1: assert (res_o == {UNITS{a_i == b_i}})
            else $error("full-width equality mismatch");
      end
      if (split_i[UNITS-2:0] == '0 && op_i == CMP_GT) begin
         assert_full_gt_R5: assert (res_o == {UNITS{a_i > b_i}})
            else $error("full-width unsigned greater mismatch");
      end
      if (op_i > 3'd5) begin
         assert_unused_op_R4: assert (res_o == '0)
            else $error("unused op code produced a nonzero result");
      end
      if (&split_i[UNITS-2:0] && op_i == CMP_EQ) begin
         for (int k = 0; k < UNITS; k++) begin
            assert_unit_eq_R6: assert (res_o[k] ==
                  (a_i[k*UNIT_W +: UNIT_W] == b_i[k*UNIT_W +: UNIT_W]))
               else $error("nibble %0d equality mismatch", k);
         end
      end
   end

   logic unused_w;
   assign unused_w = (WORD_W == 0);
endmodule

// File: tb/test_simd_lane_cmp.sv
module test_simd_lane_cmp;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] a, b;
   logic [2:0]  op;
   logic [3:0]  split;
   logic [3:0]  res;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   simd_lane_cmp i_simd_lane_cmp (
      .a_i(a), .b_i(b), .op_i(op), .split_i(split), .res_o(res)
   );

   // {a, b, op, split, expected}
   localparam int NV = 13;
   localparam logic [42:0] VEC [NV] = '{
      {16'h1234, 16'h1234, 3'd0, 4'h0, 4'hF},  // R1
      {16'h8000, 16'h0000, 3'd4, 4'h0, 4'hF},  // R5
      {16'h1235, 16'h1234, 3'd0, 4'h0, 4'h0},  // R6
      {16'h1235, 16'h1234, 3'd1, 4'h0, 4'hF},  // R6
      {16'h1235, 16'h1234, 3'd0, 4'h2, 4'hC},  // R3
      {16'h2100, 16'h1F00, 3'd4, 4'h0, 4'hF},  // R7
      {16'h2100, 16'h1F00, 3'd4, 4'hF, 4'h8},  // R7
      {16'hFFFF, 16'h0000, 3'd2, 4'h2, 4'h0},  // R5
      {16'hFFFF, 16'h0000, 3'd6, 4'h2, 4'h0},  // R4
      {16'h0001, 16'h0000, 3'd4, 4'h8, 4'hF},  // R2
      {16'h00FF, 16'h0100, 3'd2, 4'h2, 4'hC},  // R2
      {16'hABCD, 16'hABCE, 3'd3, 4'hF, 4'hF},  // R4
      {16'hABCD, 16'hABCE, 3'd5, 4'hF, 4'hE}   // R4
   };

   localparam int NP = 10;
   localparam logic [31:0] PAIRS [NP] = '{
      {16'h0000, 16'h0000}, {16'h1234, 16'h1234}, {16'hABCD, 16'hABCE},
      {16'hFFFF, 16'h0000}, {16'h0000, 16'hFFFF}, {16'h8000, 16'h0000},
      {16'hBEEF, 16'hFEED}, {16'h1235, 16'h1234}, {16'h2100, 16'h1F00},
      {16'h80F0, 16'h7F0F}
   };
   localparam logic [3:0] SPL [6] = '{4'h0, 4'h2, 4'hF, 4'h5, 4'h8, 4'h1};

   function automatic logic [3:0] model(input logic [15:0] x, input logic [15:0] y,
                                        input logic [2:0] o, input logic [3:0] sp);
      logic [3:0] r = '0;
      int s = 0;
      for (int i = 0; i < 4; i++) begin
         if (i == 3 || sp[i]) begin
            int unsigned w  = (i - s + 1) * 4;
            int unsigned m  = (32'h1 << w) - 1;
            int unsigned xv = (32'(x) >> (4 * s)) & m;
            int unsigned yv = (32'(y) >> (4 * s)) & m;
            logic v;
            case (o)
               3'd0: v = (xv == yv);
               3'd1: v = (xv != yv);
               3'd2: v = (xv <  yv);
               3'd3: v = (xv <= yv);
               3'd4: v = (xv >  yv);
               3'd5: v = (xv >= yv);
               default: v = 1'b0;
            endcase
            for (int j = s; j <= i; j++) r[j] = v;
            s = i + 1;
         end
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [3:0] exp);
      n_chk++;
      if (res !== exp) begin
         n_bad++;
         $display("FAIL %s: a=%h b=%h op=%0d split=%b got %b expected %b",
                  req, a, b, op, split, res, exp);
      end
   endtask

   task automatic apply(input logic [15:0] x, input logic [15:0] y,
                        input logic [2:0] o, input logic [3:0] sp);
      @(negedge clk);
      a = x; b = y; op = o; split = sp;
      #1;
   endtask

   initial begin
      a = '0; b = '0; op = 3'd0; split = 4'h0;
      // reset state: zero operands under equality, full lane
      repeat (2) @(negedge clk);
      #1 check("R1 reset", 4'hF);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         apply(VEC[v][42:27], VEC[v][26:11], VEC[v][10:8], VEC[v][7:4]);
         check("R1-table", VEC[v][3:0]);
      end

      // sweep against the lane model (R1 R2 R3 R4 R5 R6 R7)
      for (int p = 0; p < NP; p++)
         for (int o = 0; o < 8; o++)
            for (int s = 0; s < 6; s++) begin
               apply(PAIRS[p][31:16], PAIRS[p][15:0], 3'(o), SPL[s]);
               check("R7 sweep", model(PAIRS[p][31:16], PAIRS[p][15:0], 3'(o), SPL[s]));
            end

      // R9: change upper byte of a, lower byte lane unchanged
      apply(16'h1234, 16'h1234, 3'd0, 4'h2);
      check("R9 base", 4'hF);
      apply(16'hFF34, 16'h1234, 3'd0, 4'h2);
      check("R9 other lane", 4'h3);

      // R8: response with no clock edge in between
      a = 16'h0005; b = 16'h0009; op = 3'd2; split = 4'hF;
      #2 check("R8 no edge", 4'h1);
      b = 16'h0003;
      #2 check("R8 no edge", 4'h0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, got hang expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule